// File: doc/BRIEF.md
# Program-Cycle Status Read Encoder

This block builds the 16-bit word that a flash-style memory returns on a host read. While the memory is idle it passes array read data straight through. While a program cycle or write-timer period is running (`busy_i` high), it returns a status word built from the last word loaded before the cycle began. In that word the top bit of each byte is the complement of the loaded data. The next bit down in each byte is a toggle bit that flips after every completed read. All other bits carry the loaded data unchanged.

Software can watch for the end of a cycle in either of two ways. It can poll until the top bit of a byte reads true, or it can read twice and wait until the toggle bit stops changing. Both indications appear on both byte lanes, so a byte-wide host can poll either lane. The block also drives the output-enable control for an external tri-state data bus. The bus controls are active-low and synchronous to `clk_i`. A read access ends on the first clock where the read condition is no longer met after it was met on the previous clock.

Top module: `status_read_enc`

## Requirements
- R1: `dout_en_o` is 1 exactly when `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. Otherwise it is 0, so the bus is high-impedance whenever chip enable or output enable is high.
- R2: With `busy_i`=0, `data_o` equals `array_data_i` on all 16 bits.
- R3: With `busy_i`=1, `data_o[7]` and `data_o[15]` are the inverse of `last_data_i[7]` and `last_data_i[15]`.
- R4: With `busy_i`=1, `data_o[6]` and `data_o[14]` both equal the internal toggle state, so the two lanes always agree.
- R5: A read access is the condition of R1. When a read access ends (met on one clock, not met on the next) while `busy_i`=1, the toggle state inverts at that clock edge. Successive polling reads therefore return opposite values on bits 6 and 14, wherever in the cycle polling starts.
- R6: The toggle state does not change while a read stays asserted over several clocks, when the access is a write (`we_ni`=0), or when a read ends with `busy_i`=0. After the cycle it holds, so the toggle bits stop changing.
- R7: With `busy_i`=1, every bit except 6, 7, 14 and 15 equals the same bit of `last_data_i`.
- R8: Reset (`rst_ni` low) clears the toggle state, so the first polling read after reset returns 0 on bits 6 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| busy_i | input | 1 | Program cycle or write-timer period active |
| last_data_i | input | 16 | Last loaded word |
| array_data_i | input | 16 | Array read data |
| data_o | output | 16 | Read data to the host |
| dout_en_o | output | 1 | Drive enable for the tri-state data bus |

## Verification
The bench holds output enable low across several clocks to catch a design that advances the toggle on every clock instead of once per access. It ends accesses by raising chip enable alone and by raising output enable alone. It also ends a read with busy low and later resumes polling, to confirm the toggle value was held. It drops write enable during an otherwise valid read window, where an enable decode that ignores write enable would drive the bus. It starts polling both on the first busy clock and in the middle of the cycle, and compares every clock against a reference model. A swapped lane, an inverted bit in the wrong position or a toggle that is missing on one byte shows up as a data mismatch.

// File: rtl/srenc_pkg.sv
package srenc_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic rd_en;
    logic rd_end;
  } rd_evt_t;
endpackage

// File: rtl/srenc_rd_det.sv
module srenc_rd_det
  import srenc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_ni,
  input  logic    oe_ni,
  input  logic    we_ni,
  output rd_evt_t evt_o
);
  logic rd_en, rd_q;

  assign rd_en = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_en;
  end

  assign evt_o.rd_en  = rd_en;
  assign evt_o.rd_end = rd_q & ~rd_en;
endmodule

// File: rtl/srenc_tog.sv
module srenc_tog (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic adv_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tog_q <= 1'b0;
    else if (busy_i && adv_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  // R5
  tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && adv_i) |=> (tog_q != $past(tog_q)));

  // R6
  tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && adv_i) |=> $stable(tog_q));
endmodule

// File: rtl/srenc_lane.sv
module srenc_lane #(
  parameter int LANE_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              busy_i,
  input  logic              tog_i,
  input  logic [LANE_W-1:0] last_i,
  input  logic [LANE_W-1:0] array_i,
  output logic [LANE_W-1:0] lane_o
);
  logic [LANE_W-1:0] stat;

  always_comb begin
    stat           = last_i;
    stat[POLL_BIT] = ~last_i[POLL_BIT];
    stat[TOG_BIT]  = tog_i;
  end

  assign lane_o = busy_i ? stat : array_i;
endmodule

// File: rtl/status_read_enc.sv
module status_read_enc
  import srenc_pkg::*;
#(
  parameter int DATA_W   = WORD_W,
  parameter int LANE_W   = BYTE_W,
  parameter int POLL_BIT = LANE_W - 1,
  parameter int TOG_BIT  = LANE_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              dout_en_o
);
  localparam int LANES = DATA_W / LANE_W;

  rd_evt_t evt;
  logic    tog;

  srenc_rd_det u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce_ni),
    .oe_ni (oe_ni),
    .we_ni (we_ni),
    .evt_o (evt)
  );

  srenc_tog u_tog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_i),
    .adv_i (evt.rd_end),
    .tog_o (tog)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    srenc_lane #(
      .LANE_W  (LANE_W),
      .POLL_BIT(POLL_BIT),
      .TOG_BIT (TOG_BIT)
    ) u_lane (
      .busy_i (busy_i),
      .tog_i  (tog),
      .last_i (last_data_i[g*LANE_W +: LANE_W]),
      .array_i(array_data_i[g*LANE_W +: LANE_W]),
      .lane_o (data_o[g*LANE_W +: LANE_W])
    );
  end

  assign dout_en_o = evt.rd_en;

  // R1
  bus_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !we_ni) |-> !dout_en_o);

  // R2
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (data_o == array_data_i));

  // R3
  poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (data_o[POLL_BIT] != last_data_i[POLL_BIT]) &&
               (data_o[LANE_W+POLL_BIT] != last_data_i[LANE_W+POLL_BIT]));

  // R4
  tog_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (data_o[TOG_BIT] == data_o[LANE_W+TOG_BIT]));
endmodule

// File: tb/sim_status_read_enc.sv
module sim_status_read_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [15:0] last_d = '0, arr_d = '0;
  logic [15:0] data_o;
  logic        dout_en;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit m_tog = 0;
  bit m_prev_rd = 0;

  always #10 clk = ~clk;

  status_read_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .busy_i(busy), .last_data_i(last_d), .array_data_i(arr_d),
    .data_o(data_o), .dout_en_o(dout_en)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, then advance model
  task automatic cyc(input bit c, input bit o, input bit w, input bit b,
                     input logic [15:0] ld, input logic [15:0] ad, input string ttag);
    logic [15:0] e;
    bit rd;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; busy = b; last_d = ld; arr_d = ad;
    #5;
    rd = !c && !o && w;
    chk(dout_en == rd, "R1", {15'd0, dout_en}, {15'd0, rd});
    if (!b) begin
      chk(data_o == ad, "R2", data_o, ad);
    end else begin
      e = ld;
      e[7] = ~ld[7]; e[15] = ~ld[15];
      e[6] = m_tog;  e[14] = m_tog;
      chk({data_o[15], data_o[7]} == {e[15], e[7]}, "R3", data_o, e);
      chk({data_o[14], data_o[6]} == {e[14], e[6]}, ttag, data_o, e);
      chk((data_o & 16'h3F3F) == (e & 16'h3F3F), "R7", data_o, e);
    end
    if (m_prev_rd && !rd && b) m_tog = ~m_tog;
    m_prev_rd = rd;
  endtask

  task automatic poll(input logic [15:0] ld, input string ttag);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, ld, 16'h0, ttag);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, ld, 16'h0, "R5");
  endtask

  initial begin
    #2;
    #5 chk(dout_en == 1'b0, "R1", {15'd0, dout_en}, 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // idle reads, varied data
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a = 16'($urandom);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, a, "R2");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF, a, "R2");
    end
    // first poll after reset shows toggle 0
    poll(16'h1234, "R8");
    poll(16'h1234, "R5");
    poll(16'h80C0, "R5");
    // long read: no flip while held
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h7F3F, 16'h0, "R6");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 16'h7F3F, 16'h0, "R5"); // end via oe
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h7F3F, 16'h0, "R5");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 16'h7F3F, 16'h0, "R5"); // end via ce
    // write access is not a read
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 16'hA5A5, 16'h0, "R6");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h0, "R6");
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 16'hA5A5, 16'h0, "R6");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, 16'h0, "R6");
    // busy drops: idle reads must not move toggle
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h5A5A, 16'hBEEF, "R2");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 16'h5A5A, 16'hBEEF, "R2");
    end
    // polling resumes mid cycle
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F, 16'h0, "R6");
    for (int i = 0; i < 8; i++) poll(16'($urandom), "R5");
    // read ends on the same clock busy falls: no flip
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0, "R5");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0F0F, "R2");
    poll(16'h0000, "R6");
    // reset clears toggle
    if (m_tog == 1'b0) poll(16'h0000, "R5");
    @(negedge clk); rst_n = 1'b0; m_tog = 0; m_prev_rd = 0;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    poll(16'hC3C3, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule